// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Sequencer

This block models the digital side of a serial configuration memory that a programmable logic device reads one bit per rising edge of a configuration clock. A parameter vector holds the stored bits. An internal address counter steps through them while the memory is selected and released from reset. After the last bit the counter stops. The data output then goes to high impedance and a cascade output is driven low, so the next memory in a chain takes over with no gap.

Two control inputs set the state. An active-low chip select puts the device into standby when it is high. A shared reset line of fixed polarity holds the counter at zero when it is low. The reset line is open-drain. The block asks for it to be held low from power-up until a parameterized settling time has passed. The level that the block sees is the externally driven level ANDed with its own pull-low request.

Top module: `cfg_prom_seq`

## Requirements
- R1: After `por_n` rises, `oe_pull_low` stays at 1 for at least READY_CYCLES rising edges of `cclk`. It returns to 0 after READY_CYCLES+2 rising edges and stays at 0 from then on.
- R2: The reset level used inside the block is `oe_rst_ext` AND NOT `oe_pull_low`. While the block's own pull-low request is active, `dout_en` is 0 and `ceo` is 1, even if `oe_rst_ext` is 1 and `ce_n` is 0.
- R3: While enabled (`ce_n`=0 and the reset level is 1) and not finished, `dout_en` is 1 and `dout` shows bit a of INIT_BITS, where a is the current address. The address starts at 0 and grows by one on each rising edge, so the bit changes just after each edge.
- R4: The rising edge taken at address DEPTH-1 marks the device finished. From then on, while it stays enabled, `dout_en` is 0 and `ceo` is 0, and further edges change nothing: the address saturates and does not wrap.
- R5: With `ce_n`=0 and the reset level at 0, `dout_en` is 0, `ceo` is 1 and `low_power` is 0. At the next rising edge the address returns to 0 and the finished mark clears.
- R6: With `ce_n`=1, whatever the reset level, `low_power` is 1, `dout_en` is 0 and `ceo` is 1. At the next rising edge the address returns to 0.
- R7: When two devices share `cclk` and the reset line, and the first device's `ceo` drives the second device's `ce_n`, the combined data output carries all of the first array and then all of the second array, with no bit repeated or skipped.
- R8: `dout` is 0 whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock; the address advances on its rising edge |
| por_n | input | 1 | Asynchronous active-low power-on reset; released synchronously inside |
| ce_n | input | 1 | Active-low chip select; high means standby |
| oe_rst_ext | input | 1 | Level driven onto the shared reset line by the outside world (pull-up) |
| oe_pull_low | output | 1 | Open-drain request to hold the shared reset line low |
| dout | output | 1 | Serial data value |
| dout_en | output | 1 | Drive enable for `dout`; 0 means high impedance |
| ceo | output | 1 | Active-low cascade enable for the next device in the chain |
| low_power | output | 1 | 1 when the device is in standby |

## Verification
A wrong address shows up on the data bit at the very next sample point, because the two chained arrays hold different bit patterns. A counter that wraps or stops early instead of saturating shows up one cycle late as a repeated bit, or as `ceo` falling too early or too late. That also moves every following bit of the second device, so it cannot go unnoticed. A finished mark or address that is not cleared by standby or reset shows up at the first bit after the device is enabled again: the stream does not restart at bit 0.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [1:0] {
    CPS_STANDBY = 2'd0,
    CPS_HELD    = 2'd1,
    CPS_RUN     = 2'd2,
    CPS_DONE    = 2'd3
  } cps_mode_e;

  function automatic cps_mode_e cps_decode(input logic sel_n, input logic rst_lvl,
                                           input logic finished);
    cps_mode_e m;
    if (sel_n)         m = CPS_STANDBY;
    else if (!rst_lvl) m = CPS_HELD;
    else if (finished) m = CPS_DONE;
    else               m = CPS_RUN;
    return m;
  endfunction

endpackage

// File: rtl/cps_por_hold.sv
module cps_por_hold #(
  parameter int READY_CYCLES = 16
) (
  input  logic cclk,
  input  logic por_n,
  output logic rst_sync_n,
  output logic pull_low
);
  localparam int CW = (READY_CYCLES < 1) ? 1 : $clog2(READY_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(READY_CYCLES);

  logic       sync_q1, sync_q2;
  logic [CW-1:0] wait_q, wait_d;
  logic          wait_en;

  // reset synchronizer: asserts at once, releases on the clock
  always_ff @(posedge cclk or negedge por_n) begin
    if (!por_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= 1'b1;
      sync_q2 <= sync_q1;
    end
  end
  assign rst_sync_n = sync_q2;

  assign wait_en = (wait_q != LIMIT);
  always_comb wait_d = wait_q + 1'b1;

  always_ff @(posedge cclk or negedge rst_sync_n) begin
    if (!rst_sync_n)  wait_q <= '0;
    else if (wait_en) wait_q <= wait_d;
  end

  assign pull_low = wait_en;

  // once released, the pull request never comes back
  p_release_sticky_r1: assert property (@(posedge cclk) disable iff (!rst_sync_n)
    !pull_low |=> !pull_low);
  // the settling counter only moves forward
  p_wait_forward_r1: assert property (@(posedge cclk) disable iff (!rst_sync_n)
    pull_low |=> (wait_q == $past(wait_q) + 1'b1));

endmodule

// File: rtl/cps_addr_ctr.sv
module cps_addr_ctr #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          cclk,
  input  logic          rst_n,
  input  logic          run,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam logic [AW-1:0] TC = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;
  logic          upd;

  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    if (!run) begin
      addr_d = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (addr_q == TC) done_d = 1'b1;
      else              addr_d = addr_q + 1'b1;
    end
  end

  // clock enable: only when something can change
  assign upd = run ? !done_q : ((addr_q != '0) || done_q);

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (upd) begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr = addr_q;
  assign done = done_q;

  p_step_one_r3: assert property (@(posedge cclk) disable iff (!rst_n)
    (run && !done_q && addr_q != TC) |=> (addr_q == $past(addr_q) + 1'b1) && !done_q);
  p_mark_at_tc_r4: assert property (@(posedge cclk) disable iff (!rst_n)
    (run && !done_q && addr_q == TC) |=> done_q && (addr_q == TC));
  p_saturate_r4: assert property (@(posedge cclk) disable iff (!rst_n)
    (run && done_q) |=> done_q && (addr_q == TC));
  p_clear_r5: assert property (@(posedge cclk) disable iff (!rst_n)
    !run |=> (addr_q == '0) && !done_q);

endmodule

// File: rtl/cps_bit_rom.sv
module cps_bit_rom #(
  parameter int                 DEPTH     = 32,
  parameter int                 AW        = 5,
  parameter logic [DEPTH-1:0]   INIT_BITS = '0
) (
  input  logic [AW-1:0] addr,
  output logic          bit_o
);
  generate
    if ((1 << AW) == DEPTH) begin : g_full
      assign bit_o = INIT_BITS[addr];
    end else begin : g_partial
      always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < DEPTH; i++)
          if (addr == AW'(i)) bit_o = INIT_BITS[i];
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_prom_seq.sv
module cfg_prom_seq
  import cps_pkg::*;
#(
  parameter int               DEPTH        = 32,
  parameter int               READY_CYCLES = 16,
  parameter logic [DEPTH-1:0] INIT_BITS    = 32'hC3A5_0F96
) (
  input  logic cclk,
  input  logic por_n,
  input  logic ce_n,
  input  logic oe_rst_ext,
  output logic oe_pull_low,
  output logic dout,
  output logic dout_en,
  output logic ceo,
  output logic low_power
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          rst_sync_n;
  logic          rst_lvl;
  logic          run;
  logic          done;
  logic          rom_bit;
  logic [AW-1:0] addr;
  cps_mode_e     mode;

  cps_por_hold #(.READY_CYCLES(READY_CYCLES)) u_por (
    .cclk(cclk), .por_n(por_n), .rst_sync_n(rst_sync_n), .pull_low(oe_pull_low)
  );

  // open-drain line: own pull-low wins over the external level
  assign rst_lvl = oe_rst_ext & ~oe_pull_low;
  assign mode    = cps_decode(ce_n, rst_lvl, done);
  assign run     = (mode == CPS_RUN) || (mode == CPS_DONE);

  cps_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .cclk(cclk), .rst_n(rst_sync_n), .run(run), .addr(addr), .done(done)
  );

  cps_bit_rom #(.DEPTH(DEPTH), .AW(AW), .INIT_BITS(INIT_BITS)) u_rom (
    .addr(addr), .bit_o(rom_bit)
  );

  assign dout_en   = (mode == CPS_RUN);
  assign dout      = dout_en & rom_bit;
  assign ceo       = (mode != CPS_DONE);
  assign low_power = (mode == CPS_STANDBY);

  p_pull_blocks_r2: assert property (@(posedge cclk) disable iff (!rst_sync_n)
    oe_pull_low |-> (!dout_en && ceo));
  p_ceo_needs_enable_r4: assert property (@(posedge cclk) disable iff (!rst_sync_n)
    !ceo |-> (!ce_n && oe_rst_ext && !oe_pull_low));
  p_held_quiet_r5: assert property (@(posedge cclk) disable iff (!rst_sync_n)
    (!ce_n && !oe_rst_ext) |-> (!dout_en && ceo && !low_power));
  p_standby_r6: assert property (@(posedge cclk) disable iff (!rst_sync_n)
    ce_n |-> (low_power && !dout_en && ceo));
  p_dout_quiet_r8: assert property (@(posedge cclk) disable iff (!rst_sync_n)
    !dout_en |-> !dout);

endmodule

// File: tb/cfg_prom_seq_tb.sv
module cfg_prom_seq_tb;
  localparam int DEPTH = 32;
  localparam int RC    = 16;
  localparam logic [DEPTH-1:0] A0 = 32'hC3A5_0F96;
  localparam logic [DEPTH-1:0] A1 = 32'h5A17_E2D4;

  logic cclk = 1'b0;
  always #5 cclk = ~cclk;

  logic por_n, ce0_n, oe_drive;
  logic pl0, pl1, d0, d1, e0, e1, ceo0, ceo1, lp0, lp1;
  wire  oe_line = oe_drive & ~pl0 & ~pl1;

  cfg_prom_seq #(.DEPTH(DEPTH), .READY_CYCLES(RC), .INIT_BITS(A0)) u_dut (
    .cclk(cclk), .por_n(por_n), .ce_n(ce0_n), .oe_rst_ext(oe_line),
    .oe_pull_low(pl0), .dout(d0), .dout_en(e0), .ceo(ceo0), .low_power(lp0));
  cfg_prom_seq #(.DEPTH(DEPTH), .READY_CYCLES(RC), .INIT_BITS(A1)) u_dut2 (
    .cclk(cclk), .por_n(por_n), .ce_n(ceo0), .oe_rst_ext(oe_line),
    .oe_pull_low(pl1), .dout(d1), .dout_en(e1), .ceo(ceo1), .low_power(lp1));

  int  checks = 0;
  int  errors = 0;
  int  pos    = 0;
  bit  finished = 0;

  function automatic logic exp_bit(int p);
    return (p < DEPTH) ? A0[p] : A1[p - DEPTH];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (pos %0d)", req, what, act, exp, pos);
    end
  endtask

  // called at a falling edge; compares the ports with the bench model
  task automatic cycle_check();
    bit en;
    bit x0, x1;
    en = oe_drive && !ce0_n;
    x0 = en && (pos < DEPTH);
    x1 = en && (pos >= DEPTH) && (pos < 2*DEPTH);
    chk(e0 == x0, x0 ? "R3" : "R4/R5/R6", "dev0 dout_en", e0, x0);
    chk(e1 == x1, x1 ? "R7" : "R4/R6", "dev1 dout_en", e1, x1);
    if (x0) chk(d0 == exp_bit(pos), "R3", "dev0 bit", d0, exp_bit(pos));
    if (x1) chk(d1 == exp_bit(pos), "R7", "dev1 bit", d1, exp_bit(pos));
    chk(ceo0 == !(en && pos >= DEPTH), "R4", "dev0 ceo", ceo0, !(en && pos >= DEPTH));
    chk(ceo1 == !(en && pos >= 2*DEPTH), "R7", "dev1 ceo", ceo1, !(en && pos >= 2*DEPTH));
    chk(lp0 == ce0_n, "R6", "dev0 low_power", lp0, ce0_n);
    chk(lp1 == !(en && pos >= DEPTH), "R6", "dev1 low_power", lp1, !(en && pos >= DEPTH));
    if (!e0) chk(d0 == 1'b0, "R8", "dev0 idle dout", d0, 0);
    if (!e1) chk(d1 == 1'b0, "R8", "dev1 idle dout", d1, 0);
  endtask

  task automatic step();
    bit en;
    @(negedge cclk);
    cycle_check();
    en = oe_drive && !ce0_n;
    @(posedge cclk);
    if (!en) pos = 0;
    else if (pos < 2*DEPTH) pos++;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd4711);
    por_n    = 1'b0;
    ce0_n    = 1'b0;
    oe_drive = 1'b1;
    #23;
    por_n = 1'b1;
    // R1/R2: pull-low active through the settling time
    for (int i = 0; i < RC; i++) @(posedge cclk);
    #1;
    chk(pl0 == 1'b1, "R1", "pull_low during settle", pl0, 1);
    chk(e0 == 1'b0 && ceo0 == 1'b1, "R2", "quiet while pulled", e0, 0);
    chk(lp0 == 1'b0, "R2", "active power while pulled", lp0, 0);
    repeat (2) @(posedge cclk);
    #1;
    chk(pl0 == 1'b0 && pl1 == 1'b0, "R1", "pull_low released", pl0, 0);
    pos = 0;

    // R3 R4 R7: full chained read plus saturation
    repeat (2*DEPTH + 8) step();
    // R5: reset line low
    oe_drive = 1'b0;
    step();
    oe_drive = 1'b1;
    repeat (40) step();
    // R6: standby with both reset levels
    ce0_n = 1'b1;
    step();
    oe_drive = 1'b0;
    step();
    oe_drive = 1'b1;
    step();
    ce0_n = 1'b0;
    repeat (10) step();
    // R5 right at the handover from device 0 to device 1
    while (pos != DEPTH) step();
    oe_drive = 1'b0;
    step();
    oe_drive = 1'b1;
    repeat (5) step();

    // random bursts of standby, held reset and running
    for (int b = 0; b < 24; b++) begin
      int kind;
      int len;
      kind = $urandom_range(0, 5);
      len  = $urandom_range(1, 80);
      ce0_n    = (kind == 0);
      oe_drive = (kind == 0) ? 1'($urandom_range(0, 1)) : (kind != 1);
      for (int c = 0; c < len; c++) step();
    end
    pl_final: begin
      chk(pl0 == 1'b0, "R1", "pull_low stays released", pl0, 0);
    end
    finish_run();
  end
endmodule